// File: doc/BRIEF.md
# Bus Monitor Stack Address Manager

This block steers the RAM writes of a bus monitor into two circular recording stacks, one for per-message command entries and one for data words. It holds an eight-word pointer table that the host loads and reads back. For each stack the table gives a lower bound, an upper bound, a next-write pointer and an alert address. While a message is being recorded, the block hands each stack write the current pointer as RAM address and advances the pointer, wrapping from the upper bound back to the lower one. When the recorder signals that the message is complete, the advanced pointers are committed to the table. When the recorder signals an abort, the committed pointers are kept and the partial message is dropped.

The first three words of every command entry are filled by the block from a free-running 48-bit time stamp, most significant slice first. Each stack can raise a sticky alert when its alert address is written, which lets the host learn how full that stack is. The host clears an alert by writing a one to the matching bit.

Top module: `stack_addr_mgr`

## Requirements
- R1: While reset is held and right after it, every table word reads 0, `irq_status` is 0, `irq` is 0 and `ram_we` is 0.
- R2: A host write with `host_we` high stores `host_wdata` into table word `host_addr`, and `host_rdata` shows word `host_addr` at once. Words 0, 1, 2 and 3 are the command stack's lower bound, next pointer, upper bound and alert address. Words 4, 5, 6 and 7 hold the same four values for the data stack.
- R3: Each granted stack write drives `ram_we` high and uses that stack's current pointer as `ram_addr`. The first write of a message uses the stored next pointer, and every later write of the same stack uses the previous address plus one.
- R4: A write at a stack's upper bound is followed by a write at that stack's lower bound.
- R5: In the cycle after `msg_done`, table words 1 and 5 hold the address that each stack would write next. If the host writes one of these words in the same cycle, the commit wins.
- R6: After `msg_abort`, table words 1 and 5 keep their values, and the next message starts again at those stored pointers.
- R7: When both stacks request in the same cycle, `cmd_gnt` is high, `dat_gnt` is low and the command address is driven. The data write is granted in a later cycle while `cmd_req` is low.
- R8: The first, second and third command writes of a message carry time stamp bits 47..32, 31..16 and 15..0. The upper slice is taken live. The lower two slices come from the stamp value sampled at that first write. Further command writes carry `cmd_wdata`, and data writes carry `dat_wdata`.
- R9: `irq_status[0]` (command) or `irq_status[1]` (data) becomes 1 in the cycle after that stack writes its alert address while its enable is high. A write at the alert address with the enable low leaves the bit at 0.
- R10: A status bit stays at 1 until a cycle with the matching `irq_clr` bit high clears it. `irq` is the OR of the status bits whose enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host table write strobe |
| host_addr | input | 3 | Table word index for read and write |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Table word selected by host_addr |
| cmd_irq_en | input | 1 | Command stack alert enable |
| dat_irq_en | input | 1 | Data stack alert enable |
| irq_clr | input | 2 | Write-one-to-clear for irq_status |
| irq_status | output | 2 | Sticky alert flags, bit 0 command, bit 1 data |
| irq | output | 1 | Alert request |
| time_stamp | input | 48 | Free-running message time stamp |
| cmd_req | input | 1 | Command stack write request |
| cmd_wdata | input | 16 | Command word from the recorder |
| cmd_gnt | output | 1 | Command write taken this cycle |
| dat_req | input | 1 | Data stack write request |
| dat_wdata | input | 16 | Data word from the recorder |
| dat_gnt | output | 1 | Data write taken this cycle |
| msg_done | input | 1 | Message complete, commit pointers |
| msg_abort | input | 1 | Message dropped, keep pointers |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 16 | RAM write data |

## Verification
The bench runs a sweep of messages with a different command and data length in each, on small stacks, so that the pointers wrap at different word positions. Each address is predicted by a wrap-around model. One message ends in an abort, which tells a kept pointer apart from a committed one. The time stamp is changed after the first command word, which shows whether the lower slices are latched or taken live. The data alert address is passed first with its enable low and later with it high, and a cycle with both requests shows the fixed priority and the deferred data write.

// File: rtl/stack_addr_mgr.sv
module stack_addr_mgr #(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [2:0]      host_addr,
  input  logic [AW-1:0]   host_wdata,
  output logic [AW-1:0]   host_rdata,
  input  logic            cmd_irq_en,
  input  logic            dat_irq_en,
  input  logic [1:0]      irq_clr,
  output logic [1:0]      irq_status,
  output logic            irq,
  input  logic [3*AW-1:0] time_stamp,
  input  logic            cmd_req,
  input  logic [AW-1:0]   cmd_wdata,
  output logic            cmd_gnt,
  input  logic            dat_req,
  input  logic [AW-1:0]   dat_wdata,
  output logic            dat_gnt,
  input  logic            msg_done,
  input  logic            msg_abort,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [AW-1:0]   ram_wdata
);
  localparam int LO = 0, NX = 1, HI = 2, AL = 3;
  localparam int NWORDS = 8;

  logic [NWORDS-1:0][AW-1:0] tbl;
  logic [1:0][AW-1:0] wp, eff;
  logic [1:0] gnt, en, hit;
  logic busy;
  logic [1:0] ci;
  logic [2*AW-1:0] ts_lat;
  logic [AW-1:0] cmd_word;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, lo, hi);
    return (p == hi) ? lo : p + AW'(1);
  endfunction

  assign cmd_gnt = cmd_req;
  assign dat_gnt = dat_req & ~cmd_req;
  assign gnt     = {dat_gnt, cmd_gnt};
  assign en      = {dat_irq_en, cmd_irq_en};

  for (genvar s = 0; s < 2; s++) begin : g_stk
    assign eff[s] = busy ? wp[s] : tbl[4*s+NX];
    assign hit[s] = gnt[s] && en[s] && (eff[s] == tbl[4*s+AL]);
    always_ff @(posedge clk) begin
      if (!rst_n) wp[s] <= '0;
      else if (gnt[s]) wp[s] <= step(eff[s], tbl[4*s+LO], tbl[4*s+HI]);
      else wp[s] <= eff[s];
    end
  end

  always_comb begin
    case (ci)
      2'd0:    cmd_word = time_stamp[3*AW-1:2*AW];
      2'd1:    cmd_word = ts_lat[2*AW-1:AW];
      2'd2:    cmd_word = ts_lat[AW-1:0];
      default: cmd_word = cmd_wdata;
    endcase
  end

  assign ram_we     = cmd_req | dat_req;
  assign ram_addr   = cmd_req ? eff[0] : eff[1];
  assign ram_wdata  = cmd_req ? cmd_word : dat_wdata;
  assign host_rdata = tbl[host_addr];
  assign irq        = |(irq_status & en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ci     <= '0;
      ts_lat <= '0;
    end else if (msg_done || msg_abort) begin
      busy <= 1'b0;
      ci   <= '0;
    end else begin
      if (|gnt) busy <= 1'b1;
      if (cmd_gnt && ci != 2'd3) ci <= ci + 2'd1;
      if (cmd_gnt && ci == 2'd0) ts_lat <= time_stamp[2*AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0;
    end else begin
      if (host_we) tbl[host_addr] <= host_wdata;
      if (msg_done) begin
        tbl[NX]   <= eff[0];
        tbl[4+NX] <= eff[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_status <= '0;
    else irq_status <= (irq_status & ~irq_clr) | hit;
  end

  // R4
  cmd_in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_gnt && !host_we && tbl[LO] <= tbl[HI] && eff[0] >= tbl[LO] && eff[0] <= tbl[HI])
    |=> (eff[0] >= tbl[LO] && eff[0] <= tbl[HI]));
  // R5
  commit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> (tbl[NX] == $past(eff[0]) && tbl[4+NX] == $past(eff[1])));
  // R6
  abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_abort && !msg_done && !host_we) |=> ($stable(tbl[NX]) && $stable(tbl[4+NX])));
  // R7
  cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && dat_req) |-> (cmd_gnt && !dat_gnt && ram_we));
  // R9
  alert_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[0]) |-> $past(cmd_irq_en));
  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[1] && !irq_clr[1]) |=> irq_status[1]);
endmodule

// File: tb/test_stack_addr_mgr.sv
module test_stack_addr_mgr;
  logic clk = 0, rst_n = 0;
  logic host_we = 0; logic [2:0] host_addr = 0; logic [15:0] host_wdata = 0, host_rdata;
  logic cmd_irq_en = 0, dat_irq_en = 0; logic [1:0] irq_clr = 0, irq_status; logic irq;
  logic [47:0] time_stamp = 0;
  logic cmd_req = 0, dat_req = 0, cmd_gnt, dat_gnt, msg_done = 0, msg_abort = 0;
  logic [15:0] cmd_wdata = 0, dat_wdata = 0;
  logic ram_we; logic [15:0] ram_addr, ram_wdata;
  int n_cmp = 0, n_bad = 0;
  bit over = 0;

  localparam logic [15:0] CS = 16'h0010, CE = 16'h0014, CI = 16'h0012;
  localparam logic [15:0] DS = 16'h0040, DE = 16'h0043, DI = 16'h0041;
  logic [15:0] exp_c, exp_d;
  logic [1:0] exp_st;

  stack_addr_mgr i_stack_addr_mgr (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  function automatic logic [15:0] nxt(input logic [15:0] p, lo, hi);
    return (p == hi) ? lo : p + 16'd1;
  endfunction

  task automatic hwr(input int a, input logic [15:0] d);
    host_we = 1; host_addr = 3'(a); host_wdata = d; tick; host_we = 0;
  endtask

  task automatic hrd(input int a, input logic [15:0] exp, input string req);
    host_addr = 3'(a); #1; chk(req, host_rdata, exp);
  endtask

  task automatic run_msg(input int nc, input int nd, input bit abort, input logic [47:0] ts);
    logic [15:0] pc, pd, ed;
    pc = exp_c; pd = exp_d;
    time_stamp = ts;
    for (int k = 0; k < nc; k++) begin
      cmd_req = 1; cmd_wdata = 16'hC000 + 16'(k); #1;
      ed = (k == 0) ? ts[47:32] : (k == 1) ? ts[31:16] : (k == 2) ? ts[15:0] : 16'hC000 + 16'(k);
      chk("R3 cmd ram_we", ram_we, 1);
      chk("R3/R4 cmd addr", ram_addr, pc);
      chk("R8 cmd data", ram_wdata, ed);
      if (pc == CI && cmd_irq_en) exp_st[0] = 1;
      tick; cmd_req = 0;
      time_stamp = ~ts;
      pc = nxt(pc, CS, CE);
    end
    for (int k = 0; k < nd; k++) begin
      dat_req = 1; dat_wdata = 16'hD000 + 16'(k); #1;
      chk("R3 dat gnt", dat_gnt, 1);
      chk("R3/R4 dat addr", ram_addr, pd);
      chk("R8 dat data", ram_wdata, 16'hD000 + 16'(k));
      if (pd == DI && dat_irq_en) exp_st[1] = 1;
      tick; dat_req = 0;
      pd = nxt(pd, DS, DE);
    end
    chk("R9 status", irq_status, exp_st);
    chk("R10 irq", irq, |(exp_st & {dat_irq_en, cmd_irq_en}));
    if (abort) begin msg_abort = 1; tick; msg_abort = 0; end
    else begin msg_done = 1; tick; msg_done = 0; exp_c = pc; exp_d = pd; end
    hrd(1, exp_c, abort ? "R6 cmd next" : "R5 cmd next");
    hrd(5, exp_d, abort ? "R6 dat next" : "R5 dat next");
    chk("R10 sticky", irq_status, exp_st);
    irq_clr = 2'b11; tick; irq_clr = 0; exp_st = 0;
    chk("R10 cleared", irq_status, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!over) begin
      over = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_st = 0;
    @(negedge clk); @(negedge clk);
    for (int a = 0; a < 8; a++) hrd(a, 16'h0, "R1 table");
    chk("R1 irq", irq, 0); chk("R1 status", irq_status, 0); chk("R1 ram_we", ram_we, 0);
    rst_n = 1; tick;
    chk("R1 after", irq_status, 0);
    for (int a = 0; a < 8; a++) hwr(a, 16'hA500 + 16'(a * 37));
    for (int a = 0; a < 8; a++) hrd(a, 16'hA500 + 16'(a * 37), "R2 readback");
    hwr(0, CS); hwr(1, CS); hwr(2, CE); hwr(3, CI);
    hwr(4, DS); hwr(5, DS); hwr(6, DE); hwr(7, DI);
    exp_c = CS; exp_d = DS;
    cmd_irq_en = 1;
    for (int m = 0; m < 12; m++) begin
      if (m == 6) dat_irq_en = 1;
      run_msg((m * 3) % 7 + 1, (m * 5) % 6 + 1, m == 5, {16'(m + 1), 16'h1234 + 16'(m), 16'hBEE0 + 16'(m)});
    end
    cmd_req = 1; dat_req = 1; dat_wdata = 16'h5A5A; #1;
    chk("R7 cmd gnt", cmd_gnt, 1); chk("R7 dat held", dat_gnt, 0); chk("R7 addr", ram_addr, exp_c);
    tick; cmd_req = 0; #1;
    chk("R7 dat gnt", dat_gnt, 1); chk("R7 dat addr", ram_addr, exp_d);
    chk("R7 dat data", ram_wdata, 16'h5A5A);
    tick; dat_req = 0;
    msg_done = 1; host_we = 1; host_addr = 3'd1; host_wdata = 16'hFFFF; tick;
    msg_done = 0; host_we = 0;
    hrd(1, nxt(exp_c, CS, CE), "R5 commit wins");
    if (!over) begin
      over = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule